// File: doc/BRIEF.md
# Block-Transfer Master for a Four-Phase Ready/Ack Bus

This block is the master side of a simple parallel bus made of an address, a data bus, a `ready` strobe that the master drives and an `ack` strobe that the slave drives. A local agent hands it a request that holds a target address, a direction and a byte count. The block then moves the block as a series of 32-bit words. Each word uses one complete four-phase exchange: `ready` rises, `ack` rises, `ready` falls, `ack` falls.

Every word of a block goes to the same bus address, so the address names a logical channel rather than a memory location. For writes, each word is pulled from a local word source at the moment it is placed on the bus. For reads, each word is captured from the bus and presented on a local word sink for one cycle. The minimum number of cycles that address and data are held before `ready` rises, and the minimum number of cycles `ready` stays up after `ack` arrives, are both set by parameters in clock cycles. A byte count of zero still produces one exchange with no data. This acts as a pure synchronisation event between the two sides.

Top module: `blk_xfer_master`

## Requirements
- R1: After a synchronous reset cycle, `bus_ready`, `busy` and `done` are low and `bus_addr` and `bus_wdata` are zero.
- R2: A request on `req_valid` is accepted only while the block is idle, and `busy` is high from the following cycle. A request presented while `busy` is high has no effect: no extra bus exchange occurs and the running block's address is unchanged.
- R3: `bus_ready` rises exactly SETUP_CYC cycles after the word's address and data were loaded, either at acceptance or at the start of the next word. Address and write data do not change in the cycle `bus_ready` rises.
- R4: `bus_ready` stays high until `bus_ack` is sampled high. It falls exactly HOLD_CYC cycles after that sample.
- R5: After `bus_ready` falls, the word completes only when `bus_ack` is sampled low. The next word's setup starts at that edge, so `bus_ready` never rises while `bus_ack` is high.
- R6: For a write, each payload word is taken from `src_data` at the clock edge where `src_take` is high, and that value is driven on `bus_wdata`. `bus_wen` is high while such a word is on the bus.
- R7: For a read, the word is captured from `bus_rdata` at the first edge where `bus_ack` is sampled high. It appears on `snk_data` with `snk_valid` high for exactly one cycle after that edge.
- R8: A byte count n gives ceil(n/4) word exchanges, counting down by 4 per word while the remaining count exceeds 4. Every exchange of the block uses the request's address.
- R9: A byte count of zero gives exactly one exchange with `bus_wen` low, no `src_take` and no `snk_valid`.
- R10: `done` pulses for one cycle, with `busy` low in that same cycle, when the last word's `bus_ack` low is sampled. A request presented in the cycle `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_write | input | 1 | 1 = write block, 0 = read block |
| req_addr | input | ADDR_W | Bus address (channel) for the whole block |
| req_bytes | input | CNT_W | Byte count of the block |
| busy | output | 1 | High while a block is in progress |
| done | output | 1 | One-cycle pulse at block completion |
| src_data | input | DATA_W | Next word to be written |
| src_take | output | 1 | Word on `src_data` is consumed at this edge |
| snk_data | output | DATA_W | Word received by a read |
| snk_valid | output | 1 | One-cycle strobe for `snk_data` |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus data driven by the master |
| bus_wen | output | 1 | Master data drive enable |
| bus_rdata | input | DATA_W | Bus data driven by the slave |
| bus_ready | output | 1 | Master strobe |
| bus_ack | input | 1 | Slave strobe |

## Verification
Two functions can land in the same cycle. One is the completion of a block, signalled by the `done` pulse with the block returning to idle. The other is the acceptance of the next request. The bench raises a new request in exactly the cycle it observes `done`. It then checks that the new block begins and that its first `bus_ready` rise still comes a full SETUP_CYC cycles after acceptance. A second provocation presents a request while the block is still busy. Every bus exchange is matched against a queue of expected words, so any extra or shifted exchange is reported.

// File: rtl/bxm_pkg.sv
package bxm_pkg;

    localparam int BYTES_PER_WORD = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WAIT_ACK,
        ST_HOLD,
        ST_WAIT_REL
    } bxm_state_e;

endpackage

// File: rtl/bxm_delay_ctr.sv
// Down-counter that is reloaded on entry to a timed wait state.
module bxm_delay_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/bxm_byte_ctr.sv
// Remaining-byte counter for a block, stepped once per finished word.
module bxm_byte_ctr #(
    parameter int CNT_W = 12,
    parameter int STEP  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             more,
    output logic             payload
);

    localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec) begin
            cnt_d = (cnt_q > STEP_V) ? (cnt_q - STEP_V) : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign more    = (cnt_q > STEP_V);
    assign payload = (cnt_q != '0);

endmodule

// File: rtl/blk_xfer_master.sv
module blk_xfer_master
    import bxm_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 12,
    parameter int SETUP_CYC = 5,
    parameter int HOLD_CYC  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_bytes,
    output logic              busy,
    output logic              done,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_take,
    output logic [DATA_W-1:0] snk_data,
    output logic              snk_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wen,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    input  logic              bus_ack
);

    localparam int DLY_MAX = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int DLY_W   = $clog2(DLY_MAX + 1);
    localparam logic [DLY_W-1:0] SETUP_LD = DLY_W'(SETUP_CYC - 1);
    localparam logic [DLY_W-1:0] HOLD_LD  = DLY_W'(HOLD_CYC - 1);

    typedef struct packed {
        bxm_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              wen;
        logic              ready;
        logic              write;
        logic [DATA_W-1:0] snk_data;
        logic              snk_valid;
        logic              done;
    } regs_t;

    regs_t r_d, r_q;

    logic             dly_load;
    logic [DLY_W-1:0] dly_val;
    logic             dly_expired;
    logic             byte_load;
    logic             byte_dec;
    logic             more_words;
    logic             has_payload;
    logic             take_d;

    bxm_delay_ctr #(
        .W (DLY_W)
    ) u_dly (
        .clk      (clk),
        .rst      (rst),
        .load     (dly_load),
        .load_val (dly_val),
        .expired  (dly_expired)
    );

    bxm_byte_ctr #(
        .CNT_W (CNT_W),
        .STEP  (BYTES_PER_WORD)
    ) u_bytes (
        .clk      (clk),
        .rst      (rst),
        .load     (byte_load),
        .load_val (req_bytes),
        .dec      (byte_dec),
        .more     (more_words),
        .payload  (has_payload)
    );

    always_comb begin
        r_d           = r_q;
        r_d.snk_valid = 1'b0;
        r_d.done      = 1'b0;
        dly_load      = 1'b0;
        dly_val       = '0;
        byte_load     = 1'b0;
        byte_dec      = 1'b0;
        take_d        = 1'b0;

        case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.state = ST_SETUP;
                    r_d.addr  = req_addr;
                    r_d.write = req_write;
                    byte_load = 1'b1;
                    dly_load  = 1'b1;
                    dly_val   = SETUP_LD;
                    if (req_write && (req_bytes != '0)) begin
                        r_d.wen   = 1'b1;
                        r_d.wdata = src_data;
                        take_d    = 1'b1;
                    end else begin
                        r_d.wen   = 1'b0;
                        r_d.wdata = '0;
                    end
                end
            end
            ST_SETUP: begin
                if (dly_expired) begin
                    r_d.ready = 1'b1;
                    r_d.state = ST_WAIT_ACK;
                end
            end
            ST_WAIT_ACK: begin
                if (bus_ack) begin
                    r_d.state = ST_HOLD;
                    dly_load  = 1'b1;
                    dly_val   = HOLD_LD;
                    if (!r_q.write && has_payload) begin
                        r_d.snk_data  = bus_rdata;
                        r_d.snk_valid = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (dly_expired) begin
                    r_d.ready = 1'b0;
                    r_d.state = ST_WAIT_REL;
                end
            end
            ST_WAIT_REL: begin
                if (!bus_ack) begin
                    if (more_words) begin
                        byte_dec  = 1'b1;
                        r_d.state = ST_SETUP;
                        dly_load  = 1'b1;
                        dly_val   = SETUP_LD;
                        if (r_q.write) begin
                            r_d.wdata = src_data;
                            take_d    = 1'b1;
                        end
                    end else begin
                        r_d.state = ST_IDLE;
                        r_d.wen   = 1'b0;
                        r_d.done  = 1'b1;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.state != ST_IDLE);
    assign done      = r_q.done;
    assign src_take  = take_d;
    assign snk_data  = r_q.snk_data;
    assign snk_valid = r_q.snk_valid;
    assign bus_addr  = r_q.addr;
    assign bus_wdata = r_q.wdata;
    assign bus_wen   = r_q.wen;
    assign bus_ready = r_q.ready;

endmodule

// File: rtl/bxm_checker.sv
module bxm_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              snk_valid,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ready,
    input logic              bus_ack
);

    logic rst_prev_q = 1'b0;

    always_ff @(posedge clk) begin
        rst_prev_q <= rst;
    end

    // R1: state right after a reset cycle
    always @(posedge clk) begin
        if (rst_prev_q && !rst) begin
            a_r1_reset_state: assert (!bus_ready && !busy && !done &&
                                      bus_addr == '0 && bus_wdata == '0)
                else $error("reset state wrong");
        end
    end

    a_r3_stable_on_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ready) |-> ($stable(bus_addr) && $stable(bus_wdata)));

    a_r4_ready_until_ack: assert property (@(posedge clk) disable iff (rst)
        (bus_ready && !bus_ack) |=> bus_ready);

    a_r5_no_rise_with_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ready) |-> !$past(bus_ack));

    a_r7_sink_pulse: assert property (@(posedge clk) disable iff (rst)
        snk_valid |=> !snk_valid);

    a_r8_addr_fixed: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(bus_addr));

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

bind blk_xfer_master bxm_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .snk_valid (snk_valid),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready),
    .bus_ack   (bus_ack)
);

// File: tb/blk_xfer_master_tb.sv
module blk_xfer_master_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 12;
    localparam int T_SETUP = 4;
    localparam int T_HOLD  = 3;
    localparam int WDOG_CYC = 20000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [CNT_W-1:0]  req_bytes = '0;
    logic              busy, done, src_take, snk_valid, bus_wen, bus_ready;
    logic [DATA_W-1:0] src_data, snk_data, bus_wdata;
    logic [DATA_W-1:0] bus_rdata = '0;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_ack = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blk_xfer_master #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .CNT_W (CNT_W),
        .SETUP_CYC (T_SETUP), .HOLD_CYC (T_HOLD)
    ) u_dut (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_write (req_write),
        .req_addr (req_addr), .req_bytes (req_bytes),
        .busy (busy), .done (done),
        .src_data (src_data), .src_take (src_take),
        .snk_data (snk_data), .snk_valid (snk_valid),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_wen (bus_wen),
        .bus_rdata (bus_rdata), .bus_ready (bus_ready), .bus_ack (bus_ack)
    );

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              wr;
        logic              pl;
    } exp_t;

    exp_t exp_q[$];
    exp_t rd_q[$];

    int n_chk = 0;
    int n_fail = 0;
    int ack_dly = 0;
    int rel_dly = 0;
    int widx = 0;
    int exp_takes = 0;
    int hs_n = 0;
    int blocks = 0;
    int done_cnt = 0;
    int snk_cnt = 0;
    int exp_snk = 0;
    bit finished = 0;

    assign src_data = 32'hC0DE_0000 | DATA_W'(widx);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    // word source: advances each time the design consumes a word
    initial forever begin
        @(posedge clk);
        if (src_take) widx <= widx + 1;
    end

    // slave model, drives on falling edges
    initial begin
        int cnt = 0;
        int seq = 0;
        forever begin
            @(negedge clk);
            if (bus_ready && !bus_ack) begin
                if (cnt >= ack_dly) begin
                    bus_ack = 1'b1;
                    bus_rdata = {16'hD00D, 16'(seq)};
                    seq++;
                    cnt = 0;
                end else cnt++;
            end else if (!bus_ready && bus_ack) begin
                if (cnt >= rel_dly) begin
                    bus_ack = 1'b0;
                    bus_rdata = 32'hDEAD_BEEF;
                    cnt = 0;
                end else cnt++;
            end
        end
    end

    // monitor / scoreboard
    initial begin
        int low_cnt = 0;
        int high_cnt = 0;
        bit first_word = 0;
        logic prev_ready = 0, prev_busy = 0, prev_done = 0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (busy && !prev_busy) begin
                    first_word = 1;
                    low_cnt = 0;
                end
                if (bus_ready && !prev_ready) begin
                    chk(low_cnt == (first_word ? T_SETUP : rel_dly + 1 + T_SETUP),
                        first_word ? "R3 setup after accept" : "R5 setup after ack low",
                        32'(low_cnt), 32'(first_word ? T_SETUP : rel_dly + 1 + T_SETUP));
                    first_word = 0;
                    high_cnt = 1;
                    if (exp_q.size() == 0) begin
                        chk(0, "R2 unexpected exchange", {16'h0, bus_addr}, 32'h0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(bus_addr == e.addr, "R8 address", {16'h0, bus_addr}, {16'h0, e.addr});
                        chk(bus_wen == (e.wr && e.pl), e.pl ? "R6 wen" : "R9 wen", 32'(bus_wen), 32'(e.wr && e.pl));
                        if (e.wr && e.pl) chk(bus_wdata == e.data, "R6 write data", bus_wdata, e.data);
                        if (!e.wr && e.pl) rd_q.push_back(e);
                    end
                end else if (bus_ready) begin
                    high_cnt++;
                end else if (prev_ready) begin
                    chk(high_cnt == ack_dly + 1 + T_HOLD, "R4 ready high time",
                        32'(high_cnt), 32'(ack_dly + 1 + T_HOLD));
                    low_cnt = 1;
                end else if (busy) begin
                    low_cnt++;
                end
                if (done) begin
                    done_cnt++;
                    chk(!busy, "R10 busy low with done", 32'(busy), 32'h0);
                    chk(low_cnt == rel_dly + 1, "R10 done timing", 32'(low_cnt), 32'(rel_dly + 1));
                    chk(!prev_done, "R10 done single cycle", 32'(prev_done), 32'h0);
                end
                if (snk_valid) begin
                    snk_cnt++;
                    if (rd_q.size() == 0) begin
                        chk(0, "R7 unexpected sink word", snk_data, 32'h0);
                    end else begin
                        e = rd_q.pop_front();
                        chk(snk_data == e.data, "R7 read data", snk_data, e.data);
                    end
                end
                prev_ready = bus_ready;
                prev_busy  = busy;
                prev_done  = done;
            end
        end
    end

    // driver: one request cycle, expected words pushed to the scoreboard
    task automatic issue(input bit wr, input logic [ADDR_W-1:0] a, input int nbytes);
        int nw = (nbytes == 0) ? 1 : (nbytes + 3) / 4;
        exp_t e;
        for (int k = 0; k < nw; k++) begin
            e.addr = a;
            e.wr = wr;
            e.pl = (nbytes != 0);
            e.data = wr ? (32'hC0DE_0000 | 32'(exp_takes)) : {16'hD00D, 16'(hs_n)};
            if (wr && e.pl) exp_takes++;
            if (!wr && e.pl) exp_snk++;
            hs_n++;
            exp_q.push_back(e);
        end
        blocks++;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_bytes = CNT_W'(nbytes);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy || bus_ack);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(!bus_ready, "R1 ready low", 32'(bus_ready), 32'h0);
        chk(bus_addr == '0, "R1 address zero", {16'h0, bus_addr}, 32'h0);
        chk(bus_wdata == '0, "R1 data zero", bus_wdata, 32'h0);
        chk(!busy && !done, "R1 busy/done low", {30'h0, busy, done}, 32'h0);

        // R6 R8: write of two words
        ack_dly = 0; rel_dly = 0;
        issue(1, 16'h1234, 8);
        chk(busy, "R2 busy after accept", 32'(busy), 32'h1);
        wait_idle();

        // R7 R8: read of three words, slower slave
        ack_dly = 2; rel_dly = 1;
        issue(0, 16'h00A0, 12);
        wait_idle();

        // R8: partial final word (5 bytes -> 2 words)
        ack_dly = 1; rel_dly = 3;
        issue(1, 16'h0F0F, 5);
        wait_idle();

        // R9: zero-byte synchronisation, both directions
        ack_dly = 0; rel_dly = 2;
        issue(1, 16'h0777, 0);
        wait_idle();
        issue(0, 16'h0778, 0);
        wait_idle();

        // R2: request while busy has no effect
        ack_dly = 1; rel_dly = 0;
        issue(0, 16'h4000, 4);
        repeat (2) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'hBAD0; req_bytes = 12'd8;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();

        // R10: next request presented in the done cycle
        ack_dly = 0; rel_dly = 1;
        issue(1, 16'h5001, 4);
        do @(negedge clk); while (!done);
        issue(0, 16'h5002, 8);
        wait_idle();

        chk(exp_q.size() == 0, "R8 all exchanges seen", 32'(exp_q.size()), 32'h0);
        chk(widx == exp_takes, "R6 source words taken", 32'(widx), 32'(exp_takes));
        chk(snk_cnt == exp_snk, "R7 sink words", 32'(snk_cnt), 32'(exp_snk));
        chk(done_cnt == blocks, "R10 done count", 32'(done_cnt), 32'(blocks));
        summary();
    end

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=0", WDOG_CYC);
        summary();
    end

endmodule